// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single read or write requests into bus cycles on a shared address/data bus. Each cycle walks through four clock states: an address phase with a latch-enable pulse, a strobe phase, an optional run of wait states paced by a ready input, a data phase, and a closing state in which every strobe returns inactive. The low address bits and the data time-share one set of lines under an output enable. The upper address bits have lines of their own.

A built-in latch model rebuilds the full address from the shared lines. It stays transparent while the latch enable is high and freezes the address when the enable drops, so downstream logic sees a stable demultiplexed address for the whole cycle. A hold/acknowledge handshake lets another master take the bus. The sequencer finishes any cycle in flight, then floats its address, data and control outputs. The latch enable keeps being driven, low, during the hold.

Top module: `muxbus_seq`

## Requirements
- R1: After reset, no cycle is in progress: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `bus_oe`=0, `hlda`=0, `done`=0, `ctl_oe`=1, and `req_ready`=1 while `hold` is low.
- R2: With `ready` high, a cycle occupies exactly four clock states (T1, T2, T3, T4). `done` is high for one cycle, in the clock cycle that follows T4.
- R3: In T1, `ale`=1 for that single clock, `bus_oe`=1, `bus_out` carries address bits [DW-1:0] and `addr_hi_out` carries bits [AW-1:DW].
- R4: `lat_addr` equals the live address ({`addr_hi_out`,`bus_out`}) while `ale`=1. From the clock in which `ale` falls, it keeps that value until the next `ale` pulse.
- R5: From T2 through T3, `den_n`=0 and exactly one strobe is low: `wr_n` for a write, `rd_n` for a read. A write drives the write data on `bus_out` with `bus_oe`=1. A read releases the bus (`bus_oe`=0).
- R6: `ready` is sampled at the end of T2 and at the end of every wait state. Each low sample adds one wait state with the strobes held, so N low samples give N+2 strobe clocks.
- R7: A read captures `bus_in` at the end of T3 and presents it on `rdata` in the `done` cycle.
- R8: `dtr` is 1 for all of T1–T4 of a write and 0 for all of T1–T4 of a read.
- R9: For T1–T4, `mio` equals the request's memory flag (1 = memory, 0 = I/O) and `bhe_n` is the inverse of the request's upper-byte flag.
- R10: If `hold` rises during a cycle, the cycle still completes. After T4, or from idle, the next clock enters hold: `hlda`=1, `bus_oe`=0, `ctl_oe`=0, `ale`=0. Requests are not accepted until `hold` falls. The following clock returns to idle with `hlda`=0.
- R11: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only in idle or T4 with `hold` low, so a T4 request starts T1 on the very next clock. `req_valid` seen at any other time starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_bhe | input | 1 | Upper data byte enabled |
| req_ready | output | 1 | Request accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data, valid with done |
| bus_out | output | DW | Shared lines, outgoing value |
| bus_oe | output | 1 | Output enable for the shared lines |
| bus_in | input | DW | Shared lines, incoming value |
| addr_hi_out | output | AW-DW | Upper address lines |
| ctl_oe | output | 1 | Output enable for upper address and control lines |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dtr | output | 1 | Data direction, 1 = transmit |
| mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| bhe_n | output | 1 | Upper byte enable, active low |
| ready | input | 1 | Slave ready, low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Hold acknowledge |
| lat_addr | output | AW | Demultiplexed address from the latch model |

## Verification
The hardest case to reach from the ports is a hold request that arrives in the middle of a cycle that is stretched by wait states, while a further request is already pending. The cycle must still run out, the bus must float right after T4, and the pending request must stay parked until the hold is released. The bench gets there with a responder that counts strobe clocks and releases `ready` only after a programmed number of low samples. It raises `hold` in T2 of such a cycle and keeps `req_valid` high for the whole hold window. The same responder drives address-derived read data, so every read value and every latched address can be predicted from the request alone.

// File: rtl/muxbus_seq.sv
module muxbus_seq #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_mem,
  input  logic          req_bhe,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in,
  output logic [AW-DW-1:0] addr_hi_out,
  output logic          ctl_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dtr,
  output logic          mio,
  output logic          bhe_n,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  output logic [AW-1:0] lat_addr
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HOLD} state_t;

  state_t state, state_nx;
  logic          cw, cmem, cbhe;
  logic [AW-1:0] caddr;
  logic [DW-1:0] cwdata;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic [AW-1:0] lat_q;
  logic          strobe, active, open_slot;

  assign open_slot = (state == S_IDLE) || (state == S_T4);
  assign req_ready = open_slot && !hold;
  assign strobe    = (state == S_T2) || (state == S_TW) || (state == S_T3);
  assign active    = (state == S_T1) || strobe || (state == S_T4);

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE, S_T4: begin
        if (hold)           state_nx = S_HOLD;
        else if (req_valid) state_nx = S_T1;
        else                state_nx = S_IDLE;
      end
      S_T1:         state_nx = S_T2;
      S_T2, S_TW:   state_nx = ready ? S_T3 : S_TW;
      S_T3:         state_nx = S_T4;
      S_HOLD:       state_nx = hold ? S_HOLD : S_IDLE;
      default:      state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cw      <= 1'b0;
      cmem    <= 1'b0;
      cbhe    <= 1'b0;
      caddr   <= '0;
      cwdata  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      lat_q   <= '0;
    end else begin
      state  <= state_nx;
      done_q <= (state == S_T4);
      if (req_ready && req_valid) begin
        cw     <= req_write;
        cmem   <= req_mem;
        cbhe   <= req_bhe;
        caddr  <= req_addr;
        cwdata <= req_wdata;
      end
      if (state == S_T3 && !cw) rdata_q <= bus_in;
      if (ale) lat_q <= {addr_hi_out, bus_out};
    end
  end

  assign ale         = (state == S_T1);
  assign bus_oe      = ale || (strobe && cw);
  assign bus_out     = ale ? caddr[DW-1:0] : cwdata;
  assign addr_hi_out = caddr[AW-1:DW];
  assign rd_n        = !(strobe && !cw);
  assign wr_n        = !(strobe && cw);
  assign den_n       = !strobe;
  assign dtr         = active && cw;
  assign mio         = active && cmem;
  assign bhe_n       = !(active && cbhe);
  assign ctl_oe      = (state != S_HOLD);
  assign hlda        = (state == S_HOLD);
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign lat_addr    = ale ? {addr_hi_out, bus_out} : lat_q;

endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          den_n,
  input logic          dtr,
  input logic          bus_oe,
  input logic          ctl_oe,
  input logic          hlda,
  input logic          done,
  input logic [DW-1:0] bus_out,
  input logic [AW-DW-1:0] addr_hi_out,
  input logic [AW-1:0] lat_addr
);

  assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_strobe_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ((!rd_n || !wr_n) && !den_n));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_latch_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lat_addr == $past({addr_hi_out, bus_out})));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && $past(!ale)) |-> $stable(lat_addr));

  assert_dir_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dtr);

  assert_dir_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> dtr);

  assert_hold_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!bus_oe && !ctl_oe && !ale));

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind muxbus_seq muxbus_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .den_n(den_n), .dtr(dtr), .bus_oe(bus_oe), .ctl_oe(ctl_oe), .hlda(hlda),
  .done(done), .bus_out(bus_out), .addr_hi_out(addr_hi_out), .lat_addr(lat_addr)
);

// File: tb/muxbus_seq_tb.sv
module muxbus_seq_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_bhe = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic hold = 1'b0;
  logic req_ready, done, bus_oe, ctl_oe, ale, rd_n, wr_n, den_n, dtr, mio, bhe_n, hlda, ready;
  logic [DW-1:0] rdata, bus_out, bus_in;
  logic [AW-DW-1:0] addr_hi_out;
  logic [AW-1:0] lat_addr;

  int checks = 0;
  int fails = 0;
  int nwait = 0;
  int scnt = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    return a[DW-1:0] ^ {a[AW-1:DW], 12'h5A3};
  endfunction

  always_ff @(posedge clk) scnt <= (!rd_n || !wr_n) ? scnt + 1 : 0;
  assign ready  = (scnt >= nwait);
  assign bus_in = !rd_n ? rd_val(lat_addr) : '0;

  muxbus_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mem(req_mem), .req_bhe(req_bhe),
    .req_ready(req_ready), .done(done), .rdata(rdata), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in), .addr_hi_out(addr_hi_out), .ctl_oe(ctl_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr), .mio(mio),
    .bhe_n(bhe_n), .ready(ready), .hold(hold), .hlda(hlda), .lat_addr(lat_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit m, input bit b, input int nw, input bit hold_mid, input bit b2b);
    logic [AW-1:0] a2;
    a2 = a ^ 20'h0F0F0;
    nwait = nw;
    req_write = wr; req_addr = a; req_wdata = d; req_mem = m; req_bhe = b; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 ale in T1", ale, 1);
    chk("R3 oe in T1", bus_oe, 1);
    chk("R3 low addr", bus_out, a[DW-1:0]);
    chk("R3 high addr", addr_hi_out, a[AW-1:DW]);
    chk("R4 transparent", lat_addr, a);
    chk("R8 dtr T1", dtr, wr);
    chk("R9 mio T1", mio, m);
    chk("R9 bhe_n T1", bhe_n, !b);
    chk("R5 no strobe T1", {rd_n, wr_n, den_n}, 3'b111);
    for (int i = 0; i < nw + 2; i++) begin
      @(negedge clk);
      if (i == 0 && hold_mid) hold = 1'b1;
      chk("R5 rd_n", rd_n, wr);
      chk("R5 wr_n", wr_n, !wr);
      chk("R5 den_n", den_n, 0);
      chk("R6 ale low", ale, 0);
      chk("R11 busy", req_ready, 0);
      chk("R4 latched", lat_addr, a);
      chk("R8 dtr strobe", dtr, wr);
      chk("R5 bus_oe", bus_oe, wr);
      if (wr) chk("R5 wdata", bus_out, d);
      req_valid = (i < nw + 1);
    end
    @(negedge clk);
    chk("R2 T4 strobes off", {rd_n, wr_n, den_n, ale}, 4'b1110);
    chk("R8 dtr T4", dtr, wr);
    chk("R9 mio T4", mio, m);
    chk("R2 no done in T4", done, 0);
    chk("R11 T4 ready", req_ready, !hold_mid);
    if (b2b) begin
      req_write = 1'b0; req_addr = a2; req_mem = 1'b1; req_bhe = 1'b0; req_valid = 1'b1;
      nwait = 0;
    end
    @(negedge clk);
    chk("R2 done", done, 1);
    if (!wr) chk("R7 rdata", rdata, rd_val(a));
    if (b2b) begin
      req_valid = 1'b0;
      chk("R11 back-to-back T1", ale, 1);
      chk("R11 back-to-back addr", bus_out, a2[DW-1:0]);
      repeat (4) @(negedge clk);
      chk("R2 b2b done", done, 1);
      chk("R7 b2b rdata", rdata, rd_val(a2));
    end else if (!hold_mid) begin
      chk("R4 held after cycle", lat_addr, a);
    end
  endtask

  initial begin
    repeat (8 * 200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R1 bus_oe", bus_oe, 0);
    chk("R1 hlda", hlda, 0);
    chk("R1 done", done, 0);
    chk("R1 ctl_oe", ctl_oe, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", req_ready, 1);

    for (int idx = 0; idx < 32; idx++) begin
      logic [AW-1:0] a;
      a = 20'h01234 + idx * 20'h11111 + idx;
      do_cycle(idx[0], a, 16'hC000 ^ (idx * 16'h0101), idx[1], idx[2], idx / 8, 1'b0, 1'b0);
      @(negedge clk);
    end

    do_cycle(1'b1, 20'hABCDE, 16'h55AA, 1'b1, 1'b1, 0, 1'b0, 1'b1);
    @(negedge clk);

    do_cycle(1'b0, 20'h3C3C3, 16'h0, 1'b1, 1'b0, 2, 1'b1, 1'b0);
    chk("R10 hlda", hlda, 1);
    chk("R10 bus float", bus_oe, 0);
    chk("R10 ctl float", ctl_oe, 0);
    chk("R10 ale driven low", ale, 0);
    chk("R10 no accept", req_ready, 0);
    req_write = 1'b0; req_addr = 20'h77001; req_valid = 1'b1; nwait = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 parked ale", ale, 0);
      chk("R10 parked hlda", hlda, 1);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R10 release hlda", hlda, 0);
    chk("R10 release ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 resume T1", ale, 1);
    chk("R10 resume addr", bus_out, 16'h7001);
    repeat (4) @(negedge clk);
    chk("R10 resume done", done, 1);
    chk("R7 resume rdata", rdata, rd_val(20'h77001));

    hold = 1'b1;
    @(negedge clk);
    chk("R10 idle hold hlda", hlda, 1);
    chk("R10 idle hold ready", req_ready, 0);
    hold = 1'b0;
    @(negedge clk);
    chk("R10 idle release", hlda, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule